// File: doc/BRIEF.md
# Three-Tone Sine Sequencer

This block drives an 8-bit DAC with a repeating melody of three sine tones. A single sine lookup is addressed by a phase counter that steps through one full period of samples. A prescaler sits in front of the phase counter and lets the address advance only once every N clocks, which sets the pitch. Each of the three tones has its own N. A one-second timer moves a tone selector through the tones in order, and that selector picks which N the prescaler uses.

Only the first quarter of the sine magnitude is stored. The design computes these values while it elaborates, using a rational approximation of sine, so no memory file and no floating-point call is needed. The other three quarters come from mirroring the address and flipping the sign. On a tone change the prescaler restarts. The phase address keeps its position, so the waveform continues without a jump.

With the defaults (5000-sample period and a 50 MHz clock), the prescale ratios 13, 16 and 10 give roughly 769 Hz, 625 Hz and 1 kHz. A ratio of 1 gives 10 kHz.

Top module: `tone_player`

## Requirements
- R1: A synchronous active-high reset sets `sample` to 128, `tone_idx` to 0, the phase address to 0, and the prescaler and one-second counters to 0.
- R2: For phase address a, with half period H = DEPTH/2, p = a mod H, t = p*(H-p), D = 5*H*H - 4*t and K = floor((2048*t + D/2)/D), the table value is min(128+K, 255) when a < H and 128-K otherwise. DEPTH must be a multiple of 4.
- R3: The table value is 255 at address DEPTH/4, 0 at address 3*DEPTH/4, and 128 at addresses 0 and DEPTH/2.
- R4: `sample` is registered and shows the table value of the phase address held in the previous cycle.
- R5: While tone k (k = 0, 1, 2) is active, the phase address advances by one on every DIVk-th clock. With a ratio of 1 it advances on every clock.
- R6: The phase address counts from 0 to DEPTH-1, wraps back to 0, and never changes by anything other than one step.
- R7: `tone_idx` holds for exactly SEC_CYCLES clocks, then advances in the order 0, 1, 2, 0.
- R8: In the cycle the tone changes, the prescaler restarts from 0 and the phase address keeps its value.
- R9: `tone_idx` never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (50 MHz by default) |
| rst | input | 1 | Synchronous reset, active high |
| sample | output | 8 | Unsigned DAC code, centred on 128 |
| tone_idx | output | 2 | Index of the tone now playing |

## Verification
The assertions assume that reset is held for at least one clock before any checked behaviour. They also assume that the parameters are legal: DEPTH is a multiple of 4, every prescale ratio is at least 1, and SEC_CYCLES is at least 2. Under those assumptions the address, tone and prescaler can only move by the single steps the properties describe.

The bench uses a reduced configuration with a 40-sample period, a 200-clock tone interval and ratios of 3, 1 and 5. It starts from reset, applies a second reset partway through the run, and drives no other inputs, so every assumption holds throughout. The ratio-1 tone sweeps the whole table several times inside one interval.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int         NUM_TONES = 3;
    localparam logic [7:0] MID_LEVEL = 8'd128;

    typedef logic [1:0] tone_t;

    // Advance the tone selector: 0 -> 1 -> 2 -> 0.
    function automatic tone_t tone_next(tone_t t);
        return (t == tone_t'(NUM_TONES - 1)) ? tone_t'(0) : tone_t'(t + 2'd1);
    endfunction

    // Sine magnitude scaled to 0..128 for quarter index m of a quarter of
    // qtr samples. Rational sine approximation over a half period of
    // 2*qtr samples, rounded to nearest.
    function automatic logic [7:0] sine_mag(int m, int qtr);
        longint h;
        longint t;
        longint d;
        longint k;
        h = 2 * longint'(qtr);
        t = longint'(m) * (h - longint'(m));
        d = 5 * h * h - 4 * t;
        k = (2048 * t + d / 2) / d;
        return 8'(k);
    endfunction

endpackage

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
    parameter int DEPTH = 5000,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [7:0]    sample
);
    import tone_pkg::*;

    localparam int         QTR = DEPTH / 4;
    localparam logic [AW:0] Q1 = (AW+1)'(QTR);
    localparam logic [AW:0] Q2 = (AW+1)'(2 * QTR);
    localparam logic [AW:0] Q3 = (AW+1)'(3 * QTR);
    localparam logic [AW:0] Q4 = (AW+1)'(4 * QTR);

    // Quarter-wave magnitude table, entries 0..QTR inclusive.
    logic [7:0] mag_tbl [QTR+1];

    for (genvar g = 0; g <= QTR; g++) begin : g_ent
        localparam logic [7:0] MAG = sine_mag(g, QTR);
        assign mag_tbl[g] = MAG;
    end

    typedef struct packed {
        logic [7:0] sample;
    } rom_state_t;

    rom_state_t state_d, state_q;

    logic [AW:0] a_ext;
    logic [AW:0] m_idx;
    logic        neg_half;
    logic [7:0]  mag;
    logic [8:0]  pos_sum;

    always_comb begin
        a_ext = {1'b0, addr};
        if (a_ext < Q1) begin
            m_idx    = a_ext;
            neg_half = 1'b0;
        end else if (a_ext < Q2) begin
            m_idx    = Q2 - a_ext;
            neg_half = 1'b0;
        end else if (a_ext < Q3) begin
            m_idx    = a_ext - Q2;
            neg_half = 1'b1;
        end else begin
            m_idx    = Q4 - a_ext;
            neg_half = 1'b1;
        end
        mag     = mag_tbl[m_idx];
        pos_sum = {1'b0, MID_LEVEL} + {1'b0, mag};
        state_d = state_q;
        if (neg_half) begin
            state_d.sample = MID_LEVEL - mag;
        end else begin
            state_d.sample = pos_sum[8] ? 8'hFF : pos_sum[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.sample <= MID_LEVEL;
        end else begin
            state_q <= state_d;
        end
    end

    assign sample = state_q.sample;

endmodule

// File: rtl/tone_seq_timer.sv
module tone_seq_timer #(
    parameter int SEC_CYCLES = 50_000_000,
    parameter int SW         = $clog2(SEC_CYCLES)
) (
    input  logic            clk,
    input  logic            rst,
    output tone_pkg::tone_t tone_idx,
    output logic            expire,
    output logic [SW-1:0]   sec_cnt
);
    import tone_pkg::*;

    localparam logic [SW-1:0] SEC_LAST = SW'(SEC_CYCLES - 1);

    typedef struct packed {
        logic [SW-1:0] cnt;
        tone_t         tone;
    } tmr_state_t;

    tmr_state_t state_d, state_q;
    logic       at_end;

    always_comb begin
        at_end  = (state_q.cnt == SEC_LAST);
        state_d = state_q;
        if (at_end) begin
            state_d.cnt  = '0;
            state_d.tone = tone_next(state_q.tone);
        end else begin
            state_d.cnt  = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tone_idx = state_q.tone;
    assign expire   = at_end;
    assign sec_cnt  = state_q.cnt;

endmodule

// File: rtl/tone_phase_gen.sv
module tone_phase_gen #(
    parameter int DEPTH = 5000,
    parameter int DIV0  = 13,
    parameter int DIV1  = 16,
    parameter int DIV2  = 10,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  tone_pkg::tone_t tone_idx,
    input  logic            expire,
    output logic [AW-1:0]   addr,
    output logic [PW-1:0]   pre_cnt
);
    import tone_pkg::*;

    localparam int            RATIO [NUM_TONES] = '{DIV0, DIV1, DIV2};
    localparam logic [AW-1:0] ADDR_LAST         = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [PW-1:0] pre;
    } ph_state_t;

    ph_state_t state_d, state_q;

    // One terminal-count comparator per tone; slot 3 is never selected.
    logic [3:0] hit;
    logic       step;

    for (genvar g = 0; g < NUM_TONES; g++) begin : g_ratio
        localparam logic [PW-1:0] LAST = PW'(RATIO[g] - 1);
        assign hit[g] = (state_q.pre == LAST);
    end
    assign hit[3] = 1'b1;

    always_comb begin
        step    = hit[tone_idx];
        state_d = state_q;
        if (step) begin
            state_d.addr = (state_q.addr == ADDR_LAST) ? '0 : state_q.addr + 1'b1;
        end
        if (step || expire) begin
            state_d.pre = '0;
        end else begin
            state_d.pre = state_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr    = state_q.addr;
    assign pre_cnt = state_q.pre;

endmodule

// File: rtl/tone_player.sv
module tone_player #(
    parameter int DEPTH      = 5000,
    parameter int SEC_CYCLES = 50_000_000,
    parameter int DIV0       = 13,
    parameter int DIV1       = 16,
    parameter int DIV2       = 10
) (
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] sample,
    output logic [1:0] tone_idx
);
    import tone_pkg::*;

    localparam int AW      = $clog2(DEPTH);
    localparam int SW      = $clog2(SEC_CYCLES);
    localparam int MAX_DIV = (DIV0 > DIV1) ? ((DIV0 > DIV2) ? DIV0 : DIV2)
                                           : ((DIV1 > DIV2) ? DIV1 : DIV2);
    localparam int PW      = $clog2(MAX_DIV + 1);

    tone_t         tone_w;
    logic          expire_w;
    logic [SW-1:0] sec_w;
    logic [AW-1:0] addr_w;
    logic [PW-1:0] pre_w;

    tone_seq_timer #(
        .SEC_CYCLES (SEC_CYCLES),
        .SW         (SW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tone_idx (tone_w),
        .expire   (expire_w),
        .sec_cnt  (sec_w)
    );

    tone_phase_gen #(
        .DEPTH (DEPTH),
        .DIV0  (DIV0),
        .DIV1  (DIV1),
        .DIV2  (DIV2),
        .AW    (AW),
        .PW    (PW)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .tone_idx (tone_w),
        .expire   (expire_w),
        .addr     (addr_w),
        .pre_cnt  (pre_w)
    );

    tone_sine_rom #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr_w),
        .sample (sample)
    );

    assign tone_idx = tone_w;

endmodule

// File: rtl/tone_player_chk.sv
module tone_player_chk #(
    parameter int DEPTH      = 5000,
    parameter int SEC_CYCLES = 50_000_000,
    parameter int AW         = 13,
    parameter int SW         = 26,
    parameter int PW         = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [7:0]    sample,
    input logic [1:0]    tone_idx,
    input logic [AW-1:0] addr,
    input logic [PW-1:0] pre,
    input logic [SW-1:0] sec
);
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    // R9
    tone_range_chk: assert property (@(posedge clk) disable iff (rst)
        tone_idx <= 2'd2);

    // R7
    tone_order_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(tone_idx) |->
            tone_idx == (($past(tone_idx) == 2'd2) ? 2'd0 : $past(tone_idx) + 2'd1));

    // R7
    tone_dwell_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(tone_idx) |-> $past(sec) == SW'(SEC_CYCLES - 1));

    // R8
    pre_restart_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(tone_idx) |-> pre == '0);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(addr) |->
            (addr == $past(addr) + 1'b1) ||
            ($past(addr) == AW'(DEPTH - 1) && addr == '0));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sample == 8'd128 && tone_idx == 2'd0 && addr == '0));

    // R3
    peak_value_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(addr) == AW'(DEPTH / 4) && !$past(rst)) |-> sample == 8'd255);

    // R3
    trough_value_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(addr) == AW'(3 * DEPTH / 4) && !$past(rst)) |-> sample == 8'd0);

endmodule

bind tone_player tone_player_chk #(
    .DEPTH      (DEPTH),
    .SEC_CYCLES (SEC_CYCLES),
    .AW         (AW),
    .SW         (SW),
    .PW         (PW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sample   (sample),
    .tone_idx (tone_idx),
    .addr     (addr_w),
    .pre      (pre_w),
    .sec      (sec_w)
);

// File: tb/tb_tone_player.sv
module tb_tone_player;

    localparam int DEPTH = 40;
    localparam int SEC   = 200;
    localparam int D0    = 3;
    localparam int D1    = 1;
    localparam int D2    = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sample;
    logic [1:0] tone_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int m_sec, m_tone, m_pre, m_addr, m_sample;
    int peak_hits = 0;
    int trough_hits = 0;
    int tone_changes = 0;

    always #5 clk = ~clk;

    tone_player #(
        .DEPTH      (DEPTH),
        .SEC_CYCLES (SEC),
        .DIV0       (D0),
        .DIV1       (D1),
        .DIV2       (D2)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .tone_idx (tone_idx)
    );

    // R2: table value computed straight from the requirement's formula.
    function automatic int exp_sample(int a);
        longint h, p, t, d, k;
        h = DEPTH / 2;
        p = a % h;
        t = p * (h - p);
        d = 5 * h * h - 4 * t;
        k = (2048 * t + d / 2) / d;
        if (a < h) return (128 + k > 255) ? 255 : int'(128 + k);
        return int'(128 - k);
    endfunction

    function automatic int ratio_of(int tn);
        return (tn == 0) ? D0 : (tn == 1) ? D1 : D2;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sec = 0; m_tone = 0; m_pre = 0; m_addr = 0; m_sample = 128;
    endtask

    // One clock: advance the reference model at the edge, compare at the falling edge.
    task automatic tick();
        int adv, stp, n_tone;
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            adv      = (m_sec == SEC - 1);
            stp      = (m_pre == ratio_of(m_tone) - 1);
            m_sample = exp_sample(m_addr);
            if (stp) m_addr = (m_addr == DEPTH - 1) ? 0 : m_addr + 1;
            m_pre    = (stp || adv) ? 0 : m_pre + 1;
            m_sec    = adv ? 0 : m_sec + 1;
            n_tone   = adv ? ((m_tone == 2) ? 0 : m_tone + 1) : m_tone;
            m_tone   = n_tone;
        end
        @(negedge clk);
        // R2 R4 R5 R6 R8: every sample follows the stepped, wrapped, registered table
        check(int'(sample) == m_sample, "R2/R4/R5/R6/R8 sample", int'(sample), m_sample);
        // R7: tone index timing and order
        check(int'(tone_idx) == m_tone, "R7 tone_idx", int'(tone_idx), m_tone);
        // R9
        check(tone_idx <= 2'd2, "R9 tone range", int'(tone_idx), 2);
        if (!rst && sample == 8'd255) peak_hits++;
        if (!rst && sample == 8'd0)   trough_hits++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            logic [1:0] prev;
            prev = tone_idx;
            tick();
            if (tone_idx != prev && !rst) tone_changes++;
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // R3: the quarter points of the table, from the formula
    task automatic check_points();
        check(exp_sample(DEPTH / 4) == 255, "R3 peak point", exp_sample(DEPTH / 4), 255);
        check(exp_sample(3 * DEPTH / 4) == 0, "R3 trough point", exp_sample(3 * DEPTH / 4), 0);
        check(exp_sample(0) == 128, "R3 zero point", exp_sample(0), 128);
        check(exp_sample(DEPTH / 2) == 128, "R3 half point", exp_sample(DEPTH / 2), 128);
    endtask

    initial begin
        model_reset();
        rst = 1'b1;
        run(3);
        // R1: reset state
        check(sample == 8'd128, "R1 reset sample", int'(sample), 128);
        check(tone_idx == 2'd0, "R1 reset tone", int'(tone_idx), 0);
        rst = 1'b0;
        run(1300);
        rst = 1'b1;
        run(2);
        // R1: reset in mid-run
        check(sample == 8'd128, "R1 mid reset sample", int'(sample), 128);
        check(tone_idx == 2'd0, "R1 mid reset tone", int'(tone_idx), 0);
        rst = 1'b0;
        run(800);
        check_points();
        // R3: extremes reached at the outputs
        check(peak_hits > 0, "R3 peak observed", peak_hits, 1);
        check(trough_hits > 0, "R3 trough observed", trough_hits, 1);
        // R7: 6 changes in the first run, 4 in the second
        check(tone_changes == 10, "R7 tone change count", tone_changes, 10);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule